// File: doc/BRIEF.md
# Dual-Mode I/O Window Address Translator

This block is a slave on the CPU side. It claims CPU accesses that fall in an 8 MB window starting at 0x8000_0000 and turns each one into a single I/O-space transaction with a 16-bit port address. A one-bit mode register picks the translation. In dense mode the low 16 bits of the CPU address become the port address, so the 64 KB port space repeats across the whole window. In sparse mode each 4 KB CPU page shows only 32 ports. This lets software protect port groups page by page through its memory management unit.

The mode register is written by a CPU byte, halfword or word write whose translated port address is 0x0850. The block absorbs that write itself. It uses bit 0 of the write data and drives no I/O cycle. One transaction is handled at a time, in four states:

- `ST_IDLE` waits for a claimed request.
- `ST_ISSUE` presents the I/O request until it is granted.
- `ST_WAIT` waits for the I/O completion pulse.
- `ST_RESP` raises CPU ready for one cycle.

The transitions are:

- T_ACCEPT_IO: `ST_IDLE` to `ST_ISSUE`, for a claimed access that needs an I/O cycle.
- T_ACCEPT_LOCAL: `ST_IDLE` to `ST_RESP`, for an illegal size or a mode-register write.
- T_GRANT: `ST_ISSUE` to `ST_WAIT`, when `io_ready` is high.
- T_DONE: `ST_WAIT` to `ST_RESP`, when `io_done` is high.
- T_RETURN: `ST_RESP` to `ST_IDLE`.

Top module: `io_window_xlate`

## Requirements
- R1: An access is claimed when `c_addr[31:23]` equals 9'h100, which is 0x8000_0000 through 0x807F_FFFF. `c_claim` follows `c_valid` for claimed addresses. An unclaimed access never raises `c_ready` or `io_valid`.
- R2: In dense mode (mode 0), `io_addr` equals `c_addr[15:0]`.
- R3: In sparse mode (mode 1), `io_addr` equals `{c_addr[22:12], c_addr[4:0]}`. Address bits 11:5 have no effect.
- R4: After reset the mode is dense (0), and no request is pending on either side.
- R5: A claimed write with size 0, 1 or 2 whose translated address is 0x0850 loads the mode from `c_wdata[0]`. It issues no I/O cycle and completes with read data 0. The new mode applies from the next accepted access.
- R6: `io_size` and `io_we` copy the CPU request. Size codes are 0 for byte, 1 for halfword and 2 for word. `io_wdata` keeps only the low 1, 2 or 4 bytes of `c_wdata`, little-endian from bit 0, and the rest is zero.
- R7: For a read, `c_rdata` returns `io_rdata` masked in the same way, so a byte is zero-extended from bits 7:0 and a halfword from bits 15:0. A write returns 0.
- R8: Size code 3 is illegal. It completes with `c_rdata` all ones and no I/O cycle.
- R9: An unaligned access is forwarded unchanged in size, using the translated start address, with no fault.
- R10: Only one transaction is outstanding. `io_valid` and its request fields stay stable until `io_ready`, and `c_ready` never rises while an I/O cycle is pending.
- R11: `c_ready` is high for exactly the one cycle after `io_done` is sampled. For a locally completed access, it is high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_valid | input | 1 | CPU request valid, held until `c_ready` |
| c_addr | input | 32 | CPU byte address |
| c_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 illegal |
| c_we | input | 1 | CPU write enable |
| c_wdata | input | 32 | CPU write data, right-justified |
| c_claim | output | 1 | Request falls in the window |
| c_ready | output | 1 | One-cycle completion to CPU |
| c_rdata | output | 32 | Read data, valid with `c_ready` |
| io_valid | output | 1 | I/O request valid |
| io_ready | input | 1 | I/O request accepted |
| io_addr | output | 16 | Translated port address |
| io_size | output | 2 | I/O access size |
| io_we | output | 1 | I/O write enable |
| io_wdata | output | 32 | Lane-masked write data |
| io_done | input | 1 | I/O completion pulse |
| io_rdata | input | 32 | I/O read data, valid with `io_done` |

## Verification
The request fields can be checked at the first falling edge after the accepting rising edge, because they come straight out of registers loaded at acceptance. The CPU ready is due exactly one cycle after `io_done` is sampled, or one cycle after acceptance for a local completion. The bench raises `io_done` at a falling edge and expects `c_ready` at the very next falling edge; seeing it later, or seeing it while the I/O request is still pending, counts as a miscompare. Random grant and completion delays of zero to two cycles keep the grant and completion steps separate, so each step's latency is tested on its own.

// File: rtl/iowx_pkg.sv
package iowx_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } iowx_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } iowx_state_e;
endpackage

// File: rtl/iowx_addr_map.sv
module iowx_addr_map #(
    parameter int              CPU_AW    = 32,
    parameter int              WIN_AW    = 23,
    parameter int              IO_AW     = 16,
    parameter int              PAGE_LSB  = 12,
    parameter int              PORT_BITS = 5,
    parameter logic [CPU_AW-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              mode_sparse,
    output logic              hit,
    output logic [IO_AW-1:0]  io_addr
);
    localparam int PAGE_BITS = IO_AW - PORT_BITS;
    localparam int PAGE_MSB  = PAGE_LSB + PAGE_BITS - 1;

    logic [IO_AW-1:0] dense_addr;
    logic [IO_AW-1:0] sparse_addr;

    // Window decode: compare only the bits above the window size
    assign hit = (cpu_addr[CPU_AW-1:WIN_AW] == WIN_BASE[CPU_AW-1:WIN_AW]);

    // Dense: low offset bits alias the port space across the window
    assign dense_addr = cpu_addr[IO_AW-1:0];

    // Sparse: page number forms the upper port bits; mid-page bits are dropped
    assign sparse_addr = {cpu_addr[PAGE_MSB:PAGE_LSB], cpu_addr[PORT_BITS-1:0]};

    assign io_addr = mode_sparse ? sparse_addr : dense_addr;
endmodule

// File: rtl/iowx_lanes.sv
module iowx_lanes #(
    parameter int DW = 32
) (
    input  iowx_pkg::iowx_size_e size,
    input  logic [DW-1:0]        din,
    output logic [DW-1:0]        dout
);
    localparam int NB = DW / 8;

    logic [NB-1:0] keep;

    // Byte b is live when it lies below the access width (little-endian from lane 0)
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            keep[b] = (32'(b) < (32'd1 << size));
        end
    end

    generate
        for (genvar g = 0; g < NB; g++) begin : g_lane
            assign dout[8*g +: 8] = keep[g] ? din[8*g +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate
    import iowx_pkg::*;
#(
    parameter int               CPU_AW    = 32,
    parameter int               WIN_AW    = 23,
    parameter int               IO_AW     = 16,
    parameter int               DW        = 32,
    parameter int               PAGE_LSB  = 12,
    parameter int               PORT_BITS = 5,
    parameter logic [CPU_AW-1:0] WIN_BASE  = 32'h8000_0000,
    parameter logic [IO_AW-1:0]  CTRL_PORT = 16'h0850
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_valid,
    input  logic [CPU_AW-1:0] c_addr,
    input  logic [1:0]        c_size,
    input  logic              c_we,
    input  logic [DW-1:0]     c_wdata,
    output logic              c_claim,
    output logic              c_ready,
    output logic [DW-1:0]     c_rdata,
    output logic              io_valid,
    input  logic              io_ready,
    output logic [IO_AW-1:0]  io_addr,
    output logic [1:0]        io_size,
    output logic              io_we,
    output logic [DW-1:0]     io_wdata,
    input  logic              io_done,
    input  logic [DW-1:0]     io_rdata
);
    iowx_state_e st_q, st_d;

    logic              mode_q;
    logic [IO_AW-1:0]  lat_addr;
    iowx_size_e        lat_size;
    logic              lat_we;
    logic [DW-1:0]     lat_wdata;
    logic [DW-1:0]     rdata_q;

    logic              hit;
    logic [IO_AW-1:0]  xl_addr;
    logic [DW-1:0]     wmask;
    logic [DW-1:0]     rmask;
    iowx_size_e        req_size;

    logic              st_idle;
    logic              st_wait;
    logic              accept;
    logic              size_bad;
    logic              ctrl_wr;
    logic              io_finish;

    assign req_size = iowx_size_e'(c_size);

    iowx_addr_map #(
        .CPU_AW   (CPU_AW),
        .WIN_AW   (WIN_AW),
        .IO_AW    (IO_AW),
        .PAGE_LSB (PAGE_LSB),
        .PORT_BITS(PORT_BITS),
        .WIN_BASE (WIN_BASE)
    ) u_map (
        .cpu_addr   (c_addr),
        .mode_sparse(mode_q),
        .hit        (hit),
        .io_addr    (xl_addr)
    );

    iowx_lanes #(.DW(DW)) u_wlane (
        .size(req_size),
        .din (c_wdata),
        .dout(wmask)
    );

    iowx_lanes #(.DW(DW)) u_rlane (
        .size(lat_size),
        .din (io_rdata),
        .dout(rmask)
    );

    assign st_idle   = (st_q == ST_IDLE);
    assign st_wait   = (st_q == ST_WAIT);
    assign accept    = st_idle && c_valid && hit;
    assign size_bad  = (req_size == SZ_BAD);
    assign ctrl_wr   = c_we && !size_bad && (xl_addr == CTRL_PORT);
    assign io_finish = st_wait && io_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_d = (size_bad || ctrl_wr) ? ST_RESP : ST_ISSUE;
                end
            end
            ST_ISSUE: if (io_ready) st_d = ST_WAIT;
            ST_WAIT:  if (io_done)  st_d = ST_RESP;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Request capture, mode register and read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            lat_addr  <= '0;
            lat_size  <= SZ_BYTE;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                lat_addr  <= xl_addr;
                lat_size  <= req_size;
                lat_we    <= c_we;
                lat_wdata <= wmask;
                rdata_q   <= size_bad ? '1 : '0;
                if (ctrl_wr) begin
                    mode_q <= c_wdata[0];
                end
            end
            if (io_finish) begin
                rdata_q <= lat_we ? '0 : rmask;
            end
        end
    end

    // Outputs
    always_comb begin
        c_claim  = c_valid && hit;
        c_ready  = (st_q == ST_RESP);
        c_rdata  = rdata_q;
        io_valid = (st_q == ST_ISSUE);
        io_addr  = lat_addr;
        io_size  = lat_size;
        io_we    = lat_we;
        io_wdata = lat_wdata;
    end
endmodule

// File: rtl/iowx_checker.sv
module iowx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        c_valid,
    input logic [31:0] c_addr,
    input logic [1:0]  c_size,
    input logic        c_we,
    input logic        c_ready,
    input logic [31:0] c_rdata,
    input logic        io_valid,
    input logic        io_ready,
    input logic [15:0] io_addr,
    input logic [31:0] io_wdata,
    input logic        io_done,
    input logic        idle,
    input logic        st_wait,
    input logic        mode
);
    logic in_win;
    assign in_win = (c_addr[31:23] == 9'h100);

    // R1: an unclaimed request starts nothing
    a_r1_unclaimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle && c_valid && !in_win |=> !io_valid && !c_ready);

    // R2: dense translation of a read
    a_r2_dense_addr: assert property (@(posedge clk) disable iff (!rst_n)
        idle && c_valid && in_win && !c_we && c_size != 2'd3 && !mode
        |=> io_valid && io_addr == $past(c_addr[15:0]));

    // R3: sparse translation of a read
    a_r3_sparse_addr: assert property (@(posedge clk) disable iff (!rst_n)
        idle && c_valid && in_win && !c_we && c_size != 2'd3 && mode
        |=> io_valid && io_addr == {$past(c_addr[22:12]), $past(c_addr[4:0])});

    // R8: illegal size completes locally with all ones
    a_r8_illegal_size: assert property (@(posedge clk) disable iff (!rst_n)
        idle && c_valid && in_win && c_size == 2'd3
        |=> c_ready && !io_valid && c_rdata == 32'hFFFF_FFFF);

    // R10: request held stable until granted
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_wdata));

    // R10: no CPU completion while an I/O request is pending
    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> !c_ready);

    // R11: completion one cycle after the I/O done pulse
    a_r11_done_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        st_wait && io_done |=> c_ready);

    // R11: ready is a single-cycle pulse
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        c_ready |=> !c_ready);
endmodule

bind io_window_xlate iowx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .c_valid (c_valid),
    .c_addr  (c_addr),
    .c_size  (c_size),
    .c_we    (c_we),
    .c_ready (c_ready),
    .c_rdata (c_rdata),
    .io_valid(io_valid),
    .io_ready(io_ready),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .io_done (io_done),
    .idle    (st_idle),
    .st_wait (st_wait),
    .mode    (mode_q)
);

// File: tb/sim_io_window_xlate.sv
`timescale 1ns/1ps
module sim_io_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_valid = 1'b0;
    logic [31:0] c_addr = '0;
    logic [1:0]  c_size = '0;
    logic        c_we = 1'b0;
    logic [31:0] c_wdata = '0;
    logic        c_claim;
    logic        c_ready;
    logic [31:0] c_rdata;
    logic        io_valid;
    logic        io_ready = 1'b0;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic        io_we;
    logic [31:0] io_wdata;
    logic        io_done = 1'b0;
    logic [31:0] io_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit model_mode = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    io_window_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .c_valid(c_valid), .c_addr(c_addr), .c_size(c_size), .c_we(c_we),
        .c_wdata(c_wdata), .c_claim(c_claim), .c_ready(c_ready), .c_rdata(c_rdata),
        .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
        .io_size(io_size), .io_we(io_we), .io_wdata(io_wdata),
        .io_done(io_done), .io_rdata(io_rdata)
    );

    function automatic logic [15:0] exp_io(input logic [31:0] a, input bit m);
        return m ? {a[22:12], a[4:0]} : a[15:0];
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd, input string tag);
        bit          claim;
        bit          local_done;
        bit          saw_io;
        bit          got_rdy;
        bit          timing_ok;
        bit          done_set;
        logic [15:0] eio;
        logic [15:0] cap_addr;
        logic [1:0]  cap_size;
        logic        cap_we;
        logic [31:0] cap_wd;
        logic [31:0] devrd;
        logic [31:0] rd;
        logic [31:0] exp_rd;
        int          d1;
        int          d2;
        claim      = (a[31:23] == 9'h100);
        eio        = exp_io(a, model_mode);
        local_done = (sz == 2'd3) || (we && eio == 16'h0850);
        devrd      = $urandom;
        saw_io     = 1'b0;
        got_rdy    = 1'b0;
        timing_ok  = 1'b1;
        done_set   = 1'b0;
        rd         = '0;
        cap_addr = '0; cap_size = '0; cap_we = 1'b0; cap_wd = '0;

        @(negedge clk);
        c_valid = 1'b1; c_addr = a; c_size = sz; c_we = we; c_wdata = wd;
        #1;
        chk(c_claim == claim, {"R1 claim ", tag}, {31'd0, c_claim}, {31'd0, claim});

        if (!claim) begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (c_ready || io_valid) timing_ok = 1'b0;
            end
            c_valid = 1'b0;
            chk(timing_ok, {"R1 unclaimed quiet ", tag}, {31'd0, timing_ok}, 32'd1);
            return;
        end

        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            io_done = 1'b0;
            if (c_ready) begin
                got_rdy = 1'b1;
                rd = c_rdata;
                c_valid = 1'b0;
                if (local_done && i != 0) timing_ok = 1'b0;
                break;
            end
            if (done_set || local_done) timing_ok = 1'b0;
            if (io_valid && !saw_io) begin
                saw_io = 1'b1;
                cap_addr = io_addr; cap_size = io_size; cap_we = io_we; cap_wd = io_wdata;
                d1 = int'($urandom % 3);
                d2 = int'($urandom % 3);
                for (int k = 0; k < d1; k++) begin
                    @(negedge clk);
                    if (!io_valid || io_addr != cap_addr || io_wdata != cap_wd || c_ready)
                        timing_ok = 1'b0;
                end
                io_ready = 1'b1;
                @(negedge clk);
                io_ready = 1'b0;
                if (io_valid || c_ready) timing_ok = 1'b0;
                for (int k = 0; k < d2; k++) begin
                    @(negedge clk);
                    if (c_ready || io_valid) timing_ok = 1'b0;
                end
                io_done = 1'b1;
                io_rdata = devrd;
                done_set = 1'b1;
            end
        end
        c_valid = 1'b0;

        chk(got_rdy, {"R10 completion seen ", tag}, {31'd0, got_rdy}, 32'd1);
        chk(timing_ok, {"R11 R10 handshake timing ", tag}, {31'd0, timing_ok}, 32'd1);
        if (local_done) begin
            chk(!saw_io, {"R8 R5 no io cycle ", tag}, {31'd0, saw_io}, 32'd0);
        end else begin
            chk(saw_io, {"R2 R3 io cycle issued ", tag}, {31'd0, saw_io}, 32'd1);
            chk(cap_addr == eio, {"R2 R3 R9 io address ", tag}, {16'd0, cap_addr}, {16'd0, eio});
            chk(cap_size == sz && cap_we == we, {"R6 size and direction ", tag},
                {29'd0, cap_we, cap_size}, {29'd0, we, sz});
            if (we) chk(cap_wd == (wd & lane_mask(sz)), {"R6 write lanes ", tag},
                        cap_wd, wd & lane_mask(sz));
        end
        if (sz == 2'd3)  exp_rd = 32'hFFFF_FFFF;
        else if (we)     exp_rd = 32'h0;
        else             exp_rd = devrd & lane_mask(sz);
        chk(rd == exp_rd, {"R7 R8 read data ", tag}, rd, exp_rd);
        if (sz != 2'd3 && we && eio == 16'h0850) model_mode = wd[0];
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(!c_ready && !io_valid, "R4 reset idle", {30'd0, c_ready, io_valid}, 32'd0);
        rst_n = 1'b1;

        xfer(32'h8012_3456, 2'd0, 1'b0, 32'h0, "R4 dense after reset");
        xfer(32'h8071_1234, 2'd1, 1'b0, 32'h0, "R2 alias");
        xfer(32'h8000_0103, 2'd2, 1'b1, 32'hA1B2_C3D4, "R9 unaligned word");
        xfer(32'h8000_0201, 2'd1, 1'b1, 32'h1122_3344, "R6 half write");
        xfer(32'h8000_0850, 2'd0, 1'b1, 32'h0000_0001, "R5 enter sparse");
        xfer(32'h8004_2FF3, 2'd0, 1'b0, 32'h0, "R3 mid bits set");
        xfer(32'h8004_2013, 2'd0, 1'b0, 32'h0, "R3 mid bits clear");
        xfer(32'h807F_FFFF, 2'd2, 1'b0, 32'h0, "R1 top of window");
        xfer(32'h8080_0000, 2'd0, 1'b0, 32'h0, "R1 above window");
        xfer(32'h7FFF_FFFC, 2'd2, 1'b0, 32'h0, "R1 below window");
        xfer(32'h8000_1000, 2'd3, 1'b0, 32'h0, "R8 illegal read");
        xfer(32'h8004_2010, 2'd3, 1'b1, 32'h0, "R8 illegal to ctrl port");
        xfer(32'h8004_2FF0, 2'd0, 1'b1, 32'h0000_00FE, "R5 back to dense");
        xfer(32'h8004_2FF0, 2'd1, 1'b0, 32'h0, "R5 new mode applies");

        for (int n = 0; n < 250; n++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            logic        we;
            int          pick;
            pick = int'($urandom % 16);
            a  = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
            sz = 2'($urandom % 4);
            we = 1'($urandom % 2);
            if (pick == 0) a = $urandom;
            if (pick == 1) begin
                we = 1'b1;
                if (sz == 2'd3) sz = 2'd0;
                if (model_mode) a = 32'h8004_2010 | ($urandom & 32'h0000_0FE0);
                else            a = 32'h8000_0850 | ($urandom & 32'h007F_0000);
            end
            xfer(a, sz, we, $urandom, "random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule